// File: doc/BRIEF.md
# SAR Conversion Sequencer with Pulse-Coded Input Select

This block is the digital core of a 12-bit successive-approximation converter. A single asynchronous start pin does all the control. Its rising edge wakes the converter and opens the track window. Its falling edge freezes the sample and starts the bit search. The number of high pulses the host sends before that final fall chooses the input: one pulse gives the primary input, two pulses give the alternate input. The alternate input is either a second single-ended channel or bipolar mode, depending on the build variant.

The SAR search runs on an internal conversion clock. It drives a trial code to an external DAC and reads back one comparator bit per cycle, deciding the most significant bit first. When the search ends, the block shuts the converter down and presents the leading result bit on a data pin that it can tri-state. A host-driven serial clock then moves the result out one bit per falling edge. After the last bit, the data pin is released.

If the host starts a new conversion before it has read all bits, the next conversion is forced to the alternate input, whatever pulse pattern follows. The track/hold, DAC, comparator and reference are outside the block. They appear only as the comparator input, the DAC code output and the power and track enables.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, and whenever the start pin is low between conversions, `pwr_en` and `trk_en` are 0 and `sd_oe` is 0 until a result has been produced.
- R2: A rising start edge seen in shutdown sets `pwr_en`=1 and `trk_en`=1, and drives the data pin low (`sd_oe`=1, `sd_out`=0). The pin stays driven low for as long as `pwr_en` is 1.
- R3: A falling start edge while tracking clears `trk_en` (hold) and starts a WIDTH-bit search, deciding the MSB first. With a comparator that returns 1 when the input is at or above `dac_code`, the raw result equals the input code.
- R4: A conversion preceded by a single high pulse runs with `sel_alt`=0, and its result is straight binary.
- R5: If the start pin falls, stays low for 1 to SEL_WIN clock periods, and rises again before the search begins, `sel_alt`=1 for that conversion.
- R6: If fewer than WIDTH bits have been shifted out when the start pin next rises, the next conversion runs with `sel_alt`=1 whatever pulse pattern follows. A complete readout lets a later single pulse return to `sel_alt`=0.
- R7: When the search completes, `pwr_en` drops to 0 and the result MSB appears on `sd_out` with `sd_oe`=1, with no serial clock edge needed.
- R8: Each falling serial-clock edge in shutdown advances `sd_out` to the next lower result bit. After exactly WIDTH falls `sd_oe` returns to 0, and after WIDTH-1 falls the LSB is still driven.
- R9: With DIFFERENTIAL=1 and `sel_alt`=1, the output word is the raw code with its MSB inverted (two's complement). In every other case the output word is the raw code. With DIFFERENTIAL=0, the output is always the raw code.
- R10: From the start of hold to the result, the block uses at most SEL_WIN+WIDTH clock cycles. This is 14 cycles by default, which is 3.5 µs at a 4 MHz clock and fits the CONV_BUDGET limit.
- R11: Serial-clock falls and start-pin pulses that arrive during hold or conversion neither advance the readout nor restart or alter the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start | input | 1 | Asynchronous start pin; its pulse pattern selects the input |
| ser_clk | input | 1 | Asynchronous host serial clock; falling edges shift the result |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| pwr_en | output | 1 | Converter power enable |
| trk_en | output | 1 | 1 = track, 0 = hold (meaningful while powered) |
| sel_alt | output | 1 | 0 = primary input / unipolar, 1 = alternate input / bipolar |
| sd_out | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data drive enable; 0 = high impedance |

## Verification
The properties assume that every level on the start pin and the serial clock lasts at least one clock period, so that each edge reaches the synchronizers. They also assume the comparator is a pure function of the current DAC code. The bench drives both asynchronous pins on the falling clock edge and holds each level for one or more full periods. It drives the serial clock only in shutdown, except in the one test that deliberately injects serial-clock and start-pin edges during a conversion. The comparator is modelled as a combinational compare of a fixed input code against `dac_code`, so the search result can be predicted without reference to the design.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_SHUT   = 2'd0,
      ST_TRACK  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_CONV   = 2'd3
   } sar_state_e;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic lvl,
   output logic lvl_d
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         lvl_d <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         lvl_d <= chain[STAGES-1];
      end
   end

   assign lvl = chain[STAGES-1];

endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] dac_code,
   output logic [WIDTH-1:0] res_next,
   output logic             last
);

   logic [WIDTH-1:0] code;
   logic [WIDTH-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         mask <= '0;
      end else if (init) begin
         code <= '0;
         mask <= {1'b1, {(WIDTH-1){1'b0}}};
      end else if (step && (mask != '0)) begin
         if (cmp_hi) code <= code | mask;
         mask <= mask >> 1;
      end
   end

   assign dac_code = code | mask;
   assign res_next = cmp_hi ? (code | mask) : code;
   assign last     = step & mask[0];

endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             adv,
   output logic             sd_out,
   output logic             sd_oe,
   output logic             rd_done
);

   localparam int CNT_W = $clog2(WIDTH + 1);

   logic [WIDTH-1:0] shreg;
   logic [CNT_W-1:0] cnt;
   logic             active;
   logic             oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         cnt     <= '0;
         active  <= 1'b0;
         oe      <= 1'b0;
         rd_done <= 1'b1;
      end else if (arm) begin
         shreg  <= '0;
         oe     <= 1'b1;
         active <= 1'b0;
      end else if (load) begin
         shreg   <= load_val;
         cnt     <= '0;
         oe      <= 1'b1;
         active  <= 1'b1;
         rd_done <= 1'b0;
      end else if (adv && active) begin
         shreg <= shreg << 1;
         cnt   <= cnt + 1'b1;
         if (cnt == CNT_W'(WIDTH - 1)) begin
            oe      <= 1'b0;
            active  <= 1'b0;
            rd_done <= 1'b1;
         end
      end
   end

   assign sd_out = shreg[WIDTH-1];
   assign sd_oe  = oe;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_ctrl_pkg::*;
#(
   parameter int WIDTH        = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int SEL_WIN      = 2,
   parameter int CONV_BUDGET  = 14,
   parameter bit DIFFERENTIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnv_start,
   input  logic             ser_clk,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] dac_code,
   output logic             pwr_en,
   output logic             trk_en,
   output logic             sel_alt,
   output logic             sd_out,
   output logic             sd_oe
);

   localparam int WIN_W = $clog2(SEL_WIN + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("sar_conv_ctrl: WIDTH must be at least 2");
   end
   if (SEL_WIN < 1) begin : g_bad_win
      $error("sar_conv_ctrl: SEL_WIN must be at least 1");
   end
   if (SEL_WIN + WIDTH > CONV_BUDGET) begin : g_bad_budget
      $error("sar_conv_ctrl: hold window plus search exceeds CONV_BUDGET");
   end

   // start and serial clock synchronizers
   logic st_lvl, st_lvl_d, sc_lvl, sc_lvl_d;

   sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cnv_start),
      .lvl      (st_lvl),
      .lvl_d    (st_lvl_d)
   );

   sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ser_clk),
      .lvl      (sc_lvl),
      .lvl_d    (sc_lvl_d)
   );

   logic st_rise, st_fall, sclk_fall;
   assign st_rise   = st_lvl & ~st_lvl_d;
   assign st_fall   = ~st_lvl & st_lvl_d;
   assign sclk_fall = ~sc_lvl & sc_lvl_d;

   // sequencer
   sar_state_e       st;
   logic [WIN_W-1:0] win_cnt;
   logic             rd_done;
   logic             sar_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_SHUT;
         win_cnt <= '0;
         sel_alt <= 1'b0;
      end else begin
         case (st)
            ST_SHUT: begin
               if (st_rise) begin
                  st      <= ST_TRACK;
                  sel_alt <= ~rd_done;
               end
            end
            ST_TRACK: begin
               if (st_fall) begin
                  st      <= ST_SETTLE;
                  win_cnt <= '0;
               end
            end
            ST_SETTLE: begin
               if (st_rise) begin
                  st      <= ST_TRACK;
                  sel_alt <= 1'b1;
               end else if (win_cnt == WIN_W'(SEL_WIN - 1)) begin
                  st <= ST_CONV;
               end else begin
                  win_cnt <= win_cnt + 1'b1;
               end
            end
            ST_CONV: begin
               if (sar_last) st <= ST_SHUT;
            end
            default: st <= ST_SHUT;
         endcase
      end
   end

   logic sar_init, sar_step, arm, load, adv;
   assign sar_init = (st == ST_SETTLE);
   assign sar_step = (st == ST_CONV);
   assign arm      = (st == ST_SHUT) && st_rise;
   assign load     = (st == ST_CONV) && sar_last;
   assign adv      = (st == ST_SHUT) && sclk_fall;
   assign pwr_en   = (st != ST_SHUT);
   assign trk_en   = (st == ST_TRACK);

   // successive-approximation search
   logic [WIDTH-1:0] res_raw;

   sar_search #(.WIDTH(WIDTH)) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (sar_init),
      .step     (sar_step),
      .cmp_hi   (cmp_hi),
      .dac_code (dac_code),
      .res_next (res_raw),
      .last     (sar_last)
   );

   // output word format
   logic [WIDTH-1:0] res_fmt;

   if (DIFFERENTIAL) begin : g_diff_fmt
      assign res_fmt = sel_alt ? {~res_raw[WIDTH-1], res_raw[WIDTH-2:0]} : res_raw;
   end else begin : g_se_fmt
      assign res_fmt = res_raw;
   end

   // serial readout
   sar_shift_out #(.WIDTH(WIDTH)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .load     (load),
      .load_val (res_fmt),
      .adv      (adv),
      .sd_out   (sd_out),
      .sd_oe    (sd_oe),
      .rd_done  (rd_done)
   );

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
   parameter int WIDTH   = 12,
   parameter int SEL_WIN = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_en,
   input logic trk_en,
   input logic sel_alt,
   input logic sd_out,
   input logic sd_oe,
   input logic sclk_fall
);

   localparam int LIMIT = SEL_WIN + WIDTH;

   logic [15:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold_cnt <= '0;
      else if (pwr_en && !trk_en) hold_cnt <= hold_cnt + 16'd1;
      else                       hold_cnt <= '0;
   end

   // R1: tracking never happens while unpowered
   a_r1_track_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !trk_en);

   // R2: pin is driven low for the whole powered interval
   a_r2_dout_low_while_powered: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_en |-> (sd_oe && !sd_out));

   // R7: on completion the result is driven without a serial edge
   a_r7_msb_driven_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> sd_oe);

   // R8: the pin is released only in shutdown
   a_r8_hiz_only_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_oe) |-> !pwr_en);

   // R8: in shutdown the data pin moves only after a serial-clock fall
   a_r8_out_moves_on_sclk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && !$past(pwr_en) && !$past(sclk_fall)) |-> ($stable(sd_out) && $stable(sd_oe)));

   // R6: the selection is held through shutdown
   a_r6_sel_held_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && !$past(pwr_en)) |-> $stable(sel_alt));

   // R10: hold plus search stays within its cycle budget
   a_r10_conv_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt <= 16'(LIMIT));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH), .SEL_WIN(SEL_WIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_en    (pwr_en),
   .trk_en    (trk_en),
   .sel_alt   (sel_alt),
   .sd_out    (sd_out),
   .sd_oe     (sd_oe),
   .sclk_fall (sclk_fall)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;

   localparam int CLK_P = 10;
   localparam int W     = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnv_start = 1'b0;
   logic ser_clk = 1'b0;
   logic [W-1:0] vin_d = '0, vin_s = '0;
   logic cmp_d, cmp_s;
   logic [W-1:0] dac_d, dac_s;
   logic pwr_d, trk_d, alt_d, sdo_d, soe_d;
   logic pwr_s, trk_s, alt_s, sdo_s, soe_s;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   assign cmp_d = (vin_d >= dac_d);
   assign cmp_s = (vin_s >= dac_s);

   sar_conv_ctrl #(.DIFFERENTIAL(1'b1)) u_sar_conv_ctrl (
      .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .ser_clk(ser_clk),
      .cmp_hi(cmp_d), .dac_code(dac_d), .pwr_en(pwr_d), .trk_en(trk_d),
      .sel_alt(alt_d), .sd_out(sdo_d), .sd_oe(soe_d));

   sar_conv_ctrl #(.DIFFERENTIAL(1'b0)) u_sar_conv_ctrl_se (
      .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .ser_clk(ser_clk),
      .cmp_hi(cmp_s), .dac_code(dac_s), .pwr_en(pwr_s), .trk_en(trk_s),
      .sel_alt(alt_s), .sd_out(sdo_s), .sd_oe(soe_s));

   typedef struct packed {
      logic [W-1:0] vin;
      logic         dbl;
      logic [2:0]   lowc;
      logic         alt;
      logic [W-1:0] exp_d;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{12'h000, 1'b0, 3'd0, 1'b0, 12'h000},
      '{12'hFFF, 1'b0, 3'd0, 1'b0, 12'hFFF},
      '{12'h5A3, 1'b1, 3'd1, 1'b1, 12'hDA3},
      '{12'h800, 1'b1, 3'd2, 1'b1, 12'h000},
      '{12'h7FF, 1'b1, 3'd1, 1'b1, 12'hFFF},
      '{12'hA5C, 1'b0, 3'd0, 1'b0, 12'hA5C}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_conv(input logic [W-1:0] vd, input logic [W-1:0] vs,
                          input logic dbl, input int lowc, input logic noisy);
      vin_d = vd;
      vin_s = vs;
      cnv_start = 1'b1;
      cyc(4);
      if (dbl) begin
         cnv_start = 1'b0;
         cyc(lowc);
         cnv_start = 1'b1;
         cyc(4);
      end
      // R2: powered, tracking, pin driven low
      chk(pwr_d && trk_d, "R2 power+track", 32'({pwr_d, trk_d}), 32'h3);
      chk(soe_d && !sdo_d, "R2 pin driven low", 32'({soe_d, sdo_d}), 32'h2);
      cnv_start = 1'b0;
      if (noisy) begin
         cyc(5);
         chk(pwr_d && !trk_d, "R3 hold", 32'({pwr_d, trk_d}), 32'h2);
         cnv_start = 1'b1;   // R11: start pulse inside conversion
         cyc(2);
         cnv_start = 1'b0;
         cyc(1);
         ser_clk = 1'b1;     // R11: serial clock inside conversion
         cyc(2);
         ser_clk = 1'b0;
         cyc(16);
      end else begin
         cyc(6);
         chk(pwr_d && !trk_d, "R3 hold", 32'({pwr_d, trk_d}), 32'h2);
         cyc(20);
      end
   endtask

   task automatic read_bits(input int n, output logic [W-1:0] gd, output logic [W-1:0] gs);
      gd = '0;
      gs = '0;
      for (int i = 0; i < n; i++) begin
         gd = {gd[W-2:0], sdo_d};
         gs = {gs[W-2:0], sdo_s};
         ser_clk = 1'b1;
         cyc(2);
         ser_clk = 1'b0;
         cyc(4);
      end
   endtask

   task automatic check_done(input logic [W-1:0] exp_d, input logic [W-1:0] exp_s);
      chk(!pwr_d && soe_d, "R7 shutdown with pin driven", 32'({pwr_d, soe_d}), 32'h1);
      chk(sdo_d == exp_d[W-1], "R7 MSB without sclk", 32'(sdo_d), 32'(exp_d[W-1]));
      chk(sdo_s == exp_s[W-1], "R7 MSB single-ended", 32'(sdo_s), 32'(exp_s[W-1]));
   endtask

   initial begin : main
      logic [W-1:0] gd, gs;
      rst_n = 1'b0;
      cyc(5);
      // R1: reset state
      chk(!pwr_d && !trk_d && !soe_d, "R1 reset outputs", 32'({pwr_d, trk_d, soe_d}), 32'h0);
      chk(!pwr_s && !soe_s, "R1 reset outputs se", 32'({pwr_s, soe_s}), 32'h0);
      rst_n = 1'b1;
      cyc(3);
      // R1: serial clock before any conversion leaves the pin released
      ser_clk = 1'b1; cyc(2); ser_clk = 1'b0; cyc(4);
      chk(!soe_d && !pwr_d, "R1 idle stays released", 32'({soe_d, pwr_d}), 32'h0);

      // table of vectors: R3, R4, R5, R7, R8, R9
      for (int i = 0; i < 6; i++) begin
         do_conv(VEC[i].vin, VEC[i].vin, VEC[i].dbl, int'(VEC[i].lowc), 1'b0);
         chk(alt_d == VEC[i].alt, VEC[i].dbl ? "R5 double pulse select" : "R4 single pulse select",
             32'(alt_d), 32'(VEC[i].alt));
         chk(alt_s == VEC[i].alt, "R5/R4 select single-ended", 32'(alt_s), 32'(VEC[i].alt));
         check_done(VEC[i].exp_d, VEC[i].vin);
         read_bits(W, gd, gs);
         chk(gd == VEC[i].exp_d, "R3 R9 result word", 32'(gd), 32'(VEC[i].exp_d));
         chk(gs == VEC[i].vin, "R9 single-ended straight binary", 32'(gs), 32'(VEC[i].vin));
         chk(!soe_d && !soe_s, "R8 released after all bits", 32'({soe_d, soe_s}), 32'h0);
      end

      // R8: after WIDTH-1 falls the LSB is still driven
      do_conv(12'h001, 12'h001, 1'b0, 0, 1'b0);
      read_bits(W - 1, gd, gs);
      chk(soe_d == 1'b1, "R8 still driven after 11 falls", 32'(soe_d), 32'h1);
      chk(sdo_d == 1'b1, "R8 LSB on pin", 32'(sdo_d), 32'h1);
      read_bits(1, gd, gs);
      chk(soe_d == 1'b0, "R8 released on 12th fall", 32'(soe_d), 32'h0);

      // R6: cut-short readout forces alternate selection
      do_conv(12'h123, 12'h123, 1'b0, 0, 1'b0);
      read_bits(5, gd, gs);
      do_conv(12'h456, 12'h456, 1'b0, 0, 1'b0);
      chk(alt_d == 1'b1, "R6 forced alternate", 32'(alt_d), 32'h1);
      check_done(12'hC56, 12'h456);
      read_bits(W, gd, gs);
      chk(gd == 12'hC56, "R6 R9 forced bipolar word", 32'(gd), 32'hC56);
      chk(gs == 12'h456, "R6 R9 forced channel word", 32'(gs), 32'h456);
      do_conv(12'h321, 12'h321, 1'b0, 0, 1'b0);
      chk(alt_d == 1'b0, "R6 recovers after full read", 32'(alt_d), 32'h0);
      read_bits(W, gd, gs);
      chk(gd == 12'h321, "R6 recovered word", 32'(gd), 32'h321);

      // R11: edges during conversion are ignored
      do_conv(12'h9B7, 12'h9B7, 1'b0, 0, 1'b1);
      chk(alt_d == 1'b0, "R11 select unchanged", 32'(alt_d), 32'h0);
      check_done(12'h9B7, 12'h9B7);
      read_bits(W, gd, gs);
      chk(gd == 12'h9B7, "R11 full word after noisy conversion", 32'(gd), 32'h9B7);
      chk(!soe_d, "R11 released after 12 falls", 32'(soe_d), 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule